// File: doc/BRIEF.md
# Receive Character Buffer with Overrun Flag

This block sits between a serial receiver and the CPU. Each finished character arrives as a one-cycle strobe with its data. The block stores it in a 16-entry first-in first-out buffer. The CPU takes characters from a pop port, where the oldest stored character is always visible, and reads a data count and an empty indication.

A character can finish arriving while the buffer is already full and nothing is popped in that cycle. In that case the block keeps the stored characters, drops the new one and raises a sticky overrun flag. While the flag is up, the block signals a receive halt and ignores every later character strobe. The CPU can still drain the buffer during this time.

The flag sits in bit 0 of a 16-bit status register. Software clears it with a handshake: it reads the register while the flag is 1, then in a later cycle writes the register with bit 0 at 0. Writing 1 to the flag has no effect. A write of 0 that no such read came before also has no effect. Dropping the receive enable stops characters from being taken, but it leaves the flag as it is.

Top module: `rxq_status_top`

## Requirements
- R1: After synchronous reset, the count is 0, empty is 1, the overrun flag and rx_halt are 0, and reg_rdata reads 0x0000.
- R2: A strobe with rx_en at 1, the flag at 0 and a count below 16 stores the character. The count rises by one in the next cycle, and characters leave the pop port in arrival order.
- R3: A strobe with rx_en at 1 and the flag at 0, arriving while the count is 16 and no pop is made in that cycle, sets the flag in the next cycle. The count stays at 16, the head character does not change, and the new character is dropped.
- R4: A strobe and a pop in the same cycle at a count of 16 count as a pop followed by an accepted push. The count stays at 16, the flag stays 0, and the new character becomes the newest entry.
- R5: While the flag is 1, rx_halt is 1 and strobes store nothing. Pops still remove characters.
- R6: A register write with bit 0 at 1 leaves the flag unchanged.
- R7: A write with bit 0 at 0 clears the flag only if an earlier cycle had a reg_rd while the flag was 1, with no clear since then. A write of 0 without such a read leaves the flag at 1. Each clear uses up the read that armed it.
- R8: With rx_en at 0, strobes are ignored and the flag keeps its value.
- R9: reg_rdata bit 0 is the flag, and bits 15 to 1 always read 0. Write data in bits 15 to 1 has no effect.
- R10: A pop while the buffer is empty is ignored, and the count stays 0.
- R11: When the buffer is not empty, pop_data shows the oldest stored character without waiting for a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable; when 0, strobes are ignored |
| rx_strobe | input | 1 | One-cycle pulse per completed character |
| rx_char | input | 8 | Completed character |
| pop | input | 1 | Remove the head character |
| pop_data | output | 8 | Head (oldest) character |
| fifo_empty | output | 1 | Buffer holds no characters |
| fifo_count | output | 5 | Number of stored characters, 0 to 16 |
| rx_halt | output | 1 | Reception frozen by the overrun flag |
| reg_rd | input | 1 | Status register read strobe |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 16 | Status register write data |
| reg_rdata | output | 16 | Status register read data |

## Verification
The assertions assume that rx_strobe, pop, reg_rd and reg_wr are clean single-cycle strobes. They also assume these inputs never change between clock edges, so the cycle a handshake read lands in is unambiguous. The bench drives every input just after a falling edge and drops the strobes just after the next rising edge. It never holds a strobe across two edges unless the test calls for two separate events. Before the CPU pops or drains the buffer, the bench knows how many characters it holds. So pops on an empty buffer happen only in the test that checks that case.

// File: rtl/rxq_pkg.sv
// Package: shared constants and types for the receive character buffer.
// Assumes a single 16-bit status register with the overrun flag in bit 0.
package rxq_pkg;

    localparam int STAT_W   = 16;
    localparam int FLAG_BIT = 0;

    // Register-side events that drive the overrun flag logic.
    typedef struct packed {
        logic seen_one;   // read strobe while the flag reads 1
        logic wr_zero;    // write strobe with flag bit at 0
    } flag_evt_t;

endpackage

// File: rtl/rxq_fifo.sv
// Module: rxq_fifo
// Circular character store with first-word fall-through output.
// Assumes: the caller only raises push when there is room or a pop
// happens in the same cycle; a pop on an empty store is ignored here.
module rxq_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W-1:0] wr_ptr_nx, rd_ptr_nx;
    logic             pop_ok, push_ok;

    assign empty   = (count == '0);
    assign full    = (count == CNT_MAX);
    assign pop_ok  = pop & ~empty;
    assign push_ok = push & (~full | pop_ok);
    assign dout    = store[rd_ptr];

    // Pointer advance: natural wrap for power-of-two depth, compare otherwise.
    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_ptr_nx = wr_ptr + 1'b1;
            assign rd_ptr_nx = rd_ptr + 1'b1;
        end else begin : g_npow2
            assign wr_ptr_nx = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_ptr_nx = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    // Write a new character into the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) store[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr_nx;
            if (pop_ok)  rd_ptr <= rd_ptr_nx;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: occupancy never exceeds the depth.
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_MAX);

    // R10: a pop on an empty store with no push leaves it empty.
    a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (count == '0));

endmodule

// File: rtl/rxq_admit.sv
// Module: rxq_admit
// Decides, for each received character strobe, whether it is stored,
// dropped as an overrun, or ignored (disabled or halted).
// Assumes rx_strobe is a single-cycle pulse from the receiver.
module rxq_admit (
    input  logic rx_en,
    input  logic rx_strobe,
    input  logic halted,
    input  logic full,
    input  logic empty,
    input  logic pop,
    output logic push,
    output logic ovr_set
);

    logic live;
    logic room;

    // Classify the strobe against enable, halt and buffer room.
    always_comb begin
        live    = rx_strobe & rx_en & ~halted;
        room    = ~full | (pop & ~empty);
        push    = live & room;
        ovr_set = live & ~room;
    end

endmodule

// File: rtl/rxq_regport.sv
// Module: rxq_regport
// Status register decode: presents the flag in bit 0 with zeros above,
// and turns read and write strobes into flag events.
// Assumes a single register; write data above bit 0 is meaningless.
module rxq_regport
    import rxq_pkg::*;
(
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [STAT_W-1:0] reg_wdata,
    input  logic              flag,
    output logic [STAT_W-1:0] reg_rdata,
    output flag_evt_t         evt
);

    // Build read data and event strobes.
    always_comb begin
        reg_rdata           = '0;
        reg_rdata[FLAG_BIT] = flag;
        evt.seen_one        = reg_rd & flag;
        evt.wr_zero         = reg_wr & ~reg_wdata[FLAG_BIT];
    end

endmodule

// File: rtl/rxq_ovr_flag.sv
// Module: rxq_ovr_flag
// Sticky overrun flag with a read-then-write-zero clear handshake.
// An internal arm bit records a read that returned 1; a later write of 0
// clears the flag only while armed. A new set wins over a clear and disarms.
module rxq_ovr_flag
    import rxq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      set,
    input  flag_evt_t evt,
    output logic      flag
);

    logic armed;
    logic clr;

    assign clr = flag & armed & evt.wr_zero;

    // Flag and arm state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (set) begin
                flag  <= 1'b1;
                armed <= 1'b0;
            end else if (clr) begin
                flag  <= 1'b0;
                armed <= 1'b0;
            end else if (evt.seen_one) begin
                armed <= 1'b1;
            end
        end
    end

    // R7: the flag only falls after an armed write of zero.
    a_r7_clear_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(armed && evt.wr_zero));

    // R7: without a prior read, a write of zero keeps the flag up.
    a_r7_unarmed_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !armed && !evt.seen_one) |=> flag);

    // R3: an overrun event raises the flag next cycle.
    a_r3_set_flag: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);

endmodule

// File: rtl/rxq_status_top.sv
// Module: rxq_status_top
// Receive character buffer with an overrun status register.
// Assumes single-cycle strobes on rx_strobe, pop, reg_rd and reg_wr.
module rxq_status_top
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              rx_strobe,
    input  logic [WIDTH-1:0]  rx_char,
    input  logic              pop,
    output logic [WIDTH-1:0]  pop_data,
    output logic              fifo_empty,
    output logic [CNT_W-1:0]  fifo_count,
    output logic              rx_halt,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata
);

    logic      full;
    logic      push;
    logic      ovr_set;
    logic      flag;
    flag_evt_t evt;

    assign rx_halt = flag;

    rxq_admit u_admit (
        .rx_en     (rx_en),
        .rx_strobe (rx_strobe),
        .halted    (flag),
        .full      (full),
        .empty     (fifo_empty),
        .pop       (pop),
        .push      (push),
        .ovr_set   (ovr_set)
    );

    rxq_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (rx_char),
        .pop   (pop),
        .dout  (pop_data),
        .count (fifo_count),
        .empty (fifo_empty),
        .full  (full)
    );

    rxq_regport u_reg (
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .flag      (flag),
        .reg_rdata (reg_rdata),
        .evt       (evt)
    );

    rxq_ovr_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ovr_set),
        .evt   (evt),
        .flag  (flag)
    );

    // R3: overrun at full keeps the count and head character.
    a_r3_full_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rx_strobe && rx_en && !flag && !pop) |=>
            (fifo_count == CNT_W'(DEPTH)) && $stable(pop_data));

    // R4: push with pop at full does not overrun.
    a_r4_full_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rx_strobe && rx_en && !flag && pop) |=>
            (!rx_halt && fifo_count == CNT_W'(DEPTH)));

    // R5: while halted, the count never rises.
    a_r5_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_halt && !pop) |=> $stable(fifo_count));

    // R8: with reception disabled, the flag holds its value.
    a_r8_disable_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !reg_wr) |=> (rx_halt == $past(rx_halt)));

    // R6: writing one never drops the flag.
    a_r6_write_one: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_halt && reg_wr && reg_wdata[FLAG_BIT]) |=> rx_halt);

    // R9: upper status bits read zero.
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[STAT_W-1:1] == '0) && (reg_rdata[0] == rx_halt));

endmodule

// File: tb/rxq_status_top_test.sv
module rxq_status_top_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_en, rx_strobe, pop, reg_rd, reg_wr;
    logic [7:0]  rx_char;
    logic [7:0]  pop_data;
    logic        fifo_empty, rx_halt;
    logic [4:0]  fifo_count;
    logic [15:0] reg_wdata, reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rxq_status_top uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_strobe(rx_strobe),
        .rx_char(rx_char), .pop(pop), .pop_data(pop_data),
        .fifo_empty(fifo_empty), .fifo_count(fifo_count), .rx_halt(rx_halt),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    // Vector: strobe, en, pop, char[8], exp_count[5], exp_head[8], exp_empty
    localparam int NV = 9;
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b0, 8'h11, 5'd1, 8'h11, 1'b0},  // R2 push
        {1'b1, 1'b1, 1'b0, 8'h22, 5'd2, 8'h11, 1'b0},  // R2 push, R11 head
        {1'b0, 1'b1, 1'b1, 8'h00, 5'd1, 8'h22, 1'b0},  // R2 order
        {1'b1, 1'b1, 1'b1, 8'h33, 5'd1, 8'h33, 1'b0},  // push+pop
        {1'b0, 1'b1, 1'b1, 8'h00, 5'd0, 8'h00, 1'b1},  // drain
        {1'b0, 1'b1, 1'b1, 8'h00, 5'd0, 8'h00, 1'b1},  // R10 empty pop
        {1'b1, 1'b0, 1'b0, 8'h44, 5'd0, 8'h00, 1'b1},  // R8 disabled
        {1'b1, 1'b1, 1'b0, 8'h55, 5'd1, 8'h55, 1'b0},  // R11 head
        {1'b0, 1'b1, 1'b1, 8'h00, 5'd0, 8'h00, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive after negedge, sample 1 ns after posedge.
    task automatic cyc(input logic s, input logic [7:0] c, input logic p,
                       input logic rd, input logic wr, input logic [15:0] wd);
        @(negedge clk);
        rx_strobe = s; rx_char = c; pop = p;
        reg_rd = rd; reg_wr = wr; reg_wdata = wd;
        @(posedge clk);
        #1;
        rx_strobe = 1'b0; pop = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic fill(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) cyc(1'b1, base + 8'(i), 1'b0, 1'b0, 1'b0, 16'h0);
    endtask

    initial begin
        rst_n = 1'b0; rx_en = 1'b1; rx_strobe = 1'b0; rx_char = 8'h0;
        pop = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0; reg_wdata = 16'h0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 count", fifo_count, 0);
        check("R1 empty", fifo_empty, 1);
        check("R1 halt", rx_halt, 0);
        check("R1 rdata", reg_rdata, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int v = 0; v < NV; v++) begin
            rx_en = VEC[v][23];
            cyc(VEC[v][24], VEC[v][21:14], VEC[v][22], 1'b0, 1'b0, 16'h0);
            check("R2 R10 R8 table count", fifo_count, int'(VEC[v][13:9]));
            check("R10 table empty", fifo_empty, int'(VEC[v][0]));
            if (!VEC[v][0]) check("R11 table head", pop_data, int'(VEC[v][8:1]));
        end
        rx_en = 1'b1;

        // Fill and overrun
        fill(16, 8'hA0);
        check("R2 full count", fifo_count, 16);
        check("R11 full head", pop_data, 8'hA0);
        cyc(1'b1, 8'hEE, 1'b0, 1'b0, 1'b0, 16'h0);
        check("R3 flag set", rx_halt, 1);
        check("R3 count kept", fifo_count, 16);
        check("R3 head kept", pop_data, 8'hA0);
        // Halted: strobe ignored, pop still works
        cyc(1'b1, 8'hEF, 1'b1, 1'b0, 1'b0, 16'h0);
        check("R5 pop while halted", fifo_count, 15);
        check("R5 head after pop", pop_data, 8'hA1);
        check("R5 halt held", rx_halt, 1);
        cyc(1'b1, 8'hEF, 1'b0, 1'b0, 1'b0, 16'h0);
        check("R5 strobe ignored", fifo_count, 15);
        // Write one ignored
        cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b1, 16'h0001);
        check("R6 write one", rx_halt, 1);
        // Write zero without read
        cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b1, 16'h0000);
        check("R7 unarmed write", rx_halt, 1);
        // Receive disable keeps flag
        rx_en = 1'b0;
        cyc(1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 16'h0);
        check("R8 flag kept", rx_halt, 1);
        check("R8 count", fifo_count, 15);
        rx_en = 1'b1;
        // Read then write zero with upper bits set
        cyc(1'b0, 8'h0, 1'b0, 1'b1, 1'b0, 16'h0);
        check("R9 read value", reg_rdata, 16'h0001);
        cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b1, 16'hFFFE);
        check("R7 cleared", rx_halt, 0);
        check("R9 upper zero", reg_rdata, 16'h0000);
        // Drain in order
        for (int i = 1; i < 16; i++) begin
            check("R2 drain order", pop_data, 8'hA0 + i);
            cyc(1'b0, 8'h0, 1'b1, 1'b0, 1'b0, 16'h0);
        end
        check("R2 drained", fifo_count, 0);

        // Push with pop at full
        fill(16, 8'hB0);
        cyc(1'b1, 8'hCC, 1'b1, 1'b0, 1'b0, 16'h0);
        check("R4 no overrun", rx_halt, 0);
        check("R4 count", fifo_count, 16);
        check("R4 head", pop_data, 8'hB1);
        for (int i = 0; i < 15; i++) cyc(1'b0, 8'h0, 1'b1, 1'b0, 1'b0, 16'h0);
        check("R4 newest kept", pop_data, 8'hCC);
        check("R4 count one", fifo_count, 1);

        // Arm is consumed by a clear
        fill(15, 8'hD0);
        cyc(1'b1, 8'hEE, 1'b0, 1'b0, 1'b0, 16'h0);
        check("R3 second overrun", rx_halt, 1);
        cyc(1'b0, 8'h0, 1'b0, 1'b1, 1'b0, 16'h0);
        cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b1, 16'h0);
        check("R7 second clear", rx_halt, 0);
        cyc(1'b1, 8'hEE, 1'b0, 1'b0, 1'b0, 16'h0);
        check("R3 third overrun", rx_halt, 1);
        cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b1, 16'h0);
        check("R7 arm consumed", rx_halt, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule